// File: doc/BRIEF.md
# Serial Quad-DAC Front End

This block is the digital side of a four-channel, 10-bit digital-to-analog converter. A host drives three wires: a serial clock, a data line and an active-low chip-select/load strobe. While the strobe is low, each rising serial-clock edge shifts one data bit into a 16-bit word register. When the strobe rises, the block splits the word into an address and a code. Depending on the address, it writes one channel, writes all channels, does nothing, or puts the converter to sleep.

The four held codes and a sleep flag are the block's outputs. The analog circuits behind it are not part of this block. Sleep only raises the flag: every stored code is kept. Any later load to a non-sleep address clears the flag. A buffered copy of the bit leaving the word register is driven on a serial output, so several of these blocks can share one clock and one strobe. Chained this way, N devices act as one 16·N-bit shift path that updates together on a single strobe rise.

Top module: `qdac_serial_front`

## Requirements
- R1: While `cs_ld` is low, each rising `sck` edge shifts `din` into the word. The first bit shifted lands in word bit 15. At load, bits [15:12] are the address (MSB first), bits [11:2] are the 10-bit code (MSB first), and bits [1:0] are ignored.
- R2: On the rising edge of `cs_ld`, an address of 1, 2, 3 or 4 writes the code into channel 0, 1, 2 or 3 respectively (`dac_codes` bits [9:0], [19:10], [29:20], [39:30]). No other channel changes.
- R3: Address 15 writes the code into all four channels.
- R4: Addresses 0 and 5 through 13 leave every channel unchanged.
- R5: Address 14 sets `sleep_flag` to 1, ignores the code field and keeps every channel unchanged.
- R6: A load to any address other than 14 clears `sleep_flag`. Channels that the load does not address keep their codes.
- R7: While `cs_ld` is high, `sck` edges change neither the word nor `dout`. A later strobe pulse with no clocks re-applies the word that was held.
- R8: `dout` changes only on falling `sck` edges while `cs_ld` is low. The bit sampled from `din` on rising edge k appears on `dout` after the falling edge of rising edge k+15. A second device fed from `dout` therefore captures it on rising edge k+16, and two chained devices load their own 16-bit words on one strobe rise.
- R9: While `rst_n` is low, all codes, `sleep_flag`, `dout` and the word register are zero. This reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, same effect as power-up |
| sck | input | 1 | Serial clock; data is sampled on its rising edge |
| din | input | 1 | Serial data in |
| cs_ld | input | 1 | Active-low select; its rising edge loads the word |
| dout | output | 1 | Serial data out for chaining, updated on the falling `sck` edge |
| sleep_flag | output | 1 | High while the converter is in sleep |
| dac_codes | output | 40 | Four 10-bit held codes; channel n sits at bits [10n+9:10n] |

## Verification
The bench goes after these corner cases:
- The two ignored trailing bits are driven as ones. A design that counted fields from the wrong end would write shifted codes.
- Every no-op address, and the sleep address, is sent with a non-zero code. A decoder that let them through would corrupt a channel.
- Sleep is followed by a single-channel write and by a no-op. A design that woke only on writes, or cleared codes on sleep, would show a stale flag or lost codes.
- `sck` is toggled with `cs_ld` high, then the strobe is pulsed with no clocks. A design that kept shifting would load the junk.
- Two instances are chained and their delay is measured bit by bit. An output register on the wrong edge, or one stage too many, would give an off-by-one delay and the wrong word in the second device.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   // Address reserved for entering sleep: second-highest code of the field.
   function automatic int unsigned sleep_addr(input int unsigned addr_w);
      return (1 << addr_w) - 2;
   endfunction

   // Address that writes every channel at once: highest code of the field.
   function automatic int unsigned bcast_addr(input int unsigned addr_w);
      return (1 << addr_w) - 1;
   endfunction

   // Number of channel-select addresses the field can hold (0 and two reserved codes excluded).
   function automatic int unsigned max_channels(input int unsigned addr_w);
      return (1 << addr_w) - 3;
   endfunction

endpackage

// File: rtl/qdac_shreg.sv
module qdac_shreg #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned HEAD_W = 14
) (
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_ld,
   input  logic              din,
   output logic [HEAD_W-1:0] head,
   output logic              msb
);

   logic [WORD_W-1:0] sr;

   always_ff @(posedge sck or negedge rst_n) begin
      if (!rst_n)
         sr <= '0;
      else if (!cs_ld)
         sr <= {sr[WORD_W-2:0], din};
   end

   assign head = sr[WORD_W-1 -: HEAD_W];
   assign msb  = sr[WORD_W-1];

   // R1
   shift_in_chk: assert property (@(posedge sck) disable iff (!rst_n)
      !cs_ld |=> sr[0] == $past(din));

   // R1
   shift_move_chk: assert property (@(posedge sck) disable iff (!rst_n)
      !cs_ld |=> sr[WORD_W-1:1] == $past(sr[WORD_W-2:0]));

   // R7
   hold_when_high_chk: assert property (@(posedge sck) disable iff (!rst_n)
      cs_ld |=> $stable(sr));

endmodule

// File: rtl/qdac_dout_stage.sv
module qdac_dout_stage #(
   parameter bit ON_FALL = 1'b1
) (
   input  logic rst_n,
   input  logic sck,
   input  logic cs_ld,
   input  logic msb,
   output logic dout
);

   generate
      if (ON_FALL) begin : g_fall
         logic q;

         always_ff @(negedge sck or negedge rst_n) begin
            if (!rst_n)
               q <= 1'b0;
            else if (!cs_ld)
               q <= msb;
         end

         assign dout = q;

         // R8
         fall_capture_chk: assert property (@(negedge sck) disable iff (!rst_n)
            !cs_ld |=> dout == $past(msb));

         // R7
         out_hold_chk: assert property (@(negedge sck) disable iff (!rst_n)
            cs_ld |=> $stable(dout));
      end else begin : g_direct
         assign dout = msb;
      end
   endgenerate

endmodule

// File: rtl/qdac_hold_bank.sv
module qdac_hold_bank
   import qdac_pkg::*;
#(
   parameter int unsigned CHANNELS = 4,
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic                         rst_n,
   input  logic                         cs_ld,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [CODE_W-1:0]            code,
   output logic [CHANNELS*CODE_W-1:0]   codes,
   output logic                         asleep
);

   localparam logic [ADDR_W-1:0] SLEEP_A = ADDR_W'(sleep_addr(ADDR_W));
   localparam logic [ADDR_W-1:0] BCAST_A = ADDR_W'(bcast_addr(ADDR_W));
   localparam logic [ADDR_W-1:0] LAST_CH = ADDR_W'(CHANNELS);

   logic is_sleep;
   logic is_bcast;

   assign is_sleep = (addr == SLEEP_A);
   assign is_bcast = (addr == BCAST_A);

   generate
      for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
         localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(ch + 1);
         logic              sel;
         logic [CODE_W-1:0] q;

         assign sel = (addr == MY_A) || is_bcast;

         always_ff @(posedge cs_ld or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (sel)
               q <= code;
         end

         assign codes[ch*CODE_W +: CODE_W] = q;

         // R2
         single_write_chk: assert property (@(posedge cs_ld) disable iff (!rst_n)
            (addr == MY_A) |=> q == $past(code));
      end
   endgenerate

   always_ff @(posedge cs_ld or negedge rst_n) begin
      if (!rst_n)
         asleep <= 1'b0;
      else
         asleep <= is_sleep;
   end

   // R3
   bcast_write_chk: assert property (@(posedge cs_ld) disable iff (!rst_n)
      (addr == BCAST_A) |=> codes == {CHANNELS{$past(code)}});

   // R4
   noop_keep_chk: assert property (@(posedge cs_ld) disable iff (!rst_n)
      ((addr == '0) || ((addr > LAST_CH) && (addr < SLEEP_A))) |=> $stable(codes));

   // R5
   sleep_keep_chk: assert property (@(posedge cs_ld) disable iff (!rst_n)
      (addr == SLEEP_A) |=> (asleep && $stable(codes)));

   // R6
   wake_chk: assert property (@(posedge cs_ld) disable iff (!rst_n)
      (addr != SLEEP_A) |=> !asleep);

endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
   import qdac_pkg::*;
#(
   parameter int unsigned CHANNELS = 4,
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned WORD_W   = 16,
   parameter bit          DOUT_ON_FALL = 1'b1
) (
   input  logic                       rst_n,
   input  logic                       sck,
   input  logic                       din,
   input  logic                       cs_ld,
   output logic                       dout,
   output logic                       sleep_flag,
   output logic [CHANNELS*CODE_W-1:0] dac_codes
);

   localparam int unsigned HEAD_W = ADDR_W + CODE_W;

   generate
      if (HEAD_W > WORD_W) begin : g_bad_word
         $error("word too short for address and code fields");
      end
      if (CHANNELS < 1 || CHANNELS > max_channels(ADDR_W)) begin : g_bad_ch
         $error("channel count does not fit the address field");
      end
      if (WORD_W < 2) begin : g_bad_len
         $error("word must hold at least two bits");
      end
   endgenerate

   logic [HEAD_W-1:0] head;
   logic              msb;

   qdac_shreg #(
      .WORD_W (WORD_W),
      .HEAD_W (HEAD_W)
   ) u_shreg (
      .rst_n (rst_n),
      .sck   (sck),
      .cs_ld (cs_ld),
      .din   (din),
      .head  (head),
      .msb   (msb)
   );

   qdac_hold_bank #(
      .CHANNELS (CHANNELS),
      .CODE_W   (CODE_W),
      .ADDR_W   (ADDR_W)
   ) u_bank (
      .rst_n  (rst_n),
      .cs_ld  (cs_ld),
      .addr   (head[HEAD_W-1 -: ADDR_W]),
      .code   (head[CODE_W-1:0]),
      .codes  (dac_codes),
      .asleep (sleep_flag)
   );

   qdac_dout_stage #(
      .ON_FALL (DOUT_ON_FALL)
   ) u_dout (
      .rst_n (rst_n),
      .sck   (sck),
      .cs_ld (cs_ld),
      .msb   (msb),
      .dout  (dout)
   );

   // R9
   reset_clear_chk: assert property (@(negedge sck)
      !rst_n |-> (dac_codes == '0 && !sleep_flag && !dout));

endmodule

// File: tb/qdac_serial_front_bench.sv
module qdac_serial_front_bench;

   logic        rst_n = 1'b0;
   logic        sck   = 1'b0;
   logic        din   = 1'b0;
   logic        cs_ld = 1'b1;
   logic        cs_tail = 1'b1;
   logic        dout, dout_tail;
   logic        sleep_flag, sleep_tail;
   logic [39:0] dac_codes, codes_tail;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [9:0] m_code [4];
   bit         m_sleep;

   qdac_serial_front u_qdac_serial_front (
      .rst_n (rst_n), .sck (sck), .din (din), .cs_ld (cs_ld),
      .dout (dout), .sleep_flag (sleep_flag), .dac_codes (dac_codes)
   );

   qdac_serial_front u_qdac_serial_front_tail (
      .rst_n (rst_n), .sck (sck), .din (dout), .cs_ld (cs_tail),
      .dout (dout_tail), .sleep_flag (sleep_tail), .dac_codes (codes_tail)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void model_load(input logic [15:0] w);
      logic [3:0] a;
      logic [9:0] d;
      a = w[15:12];
      d = w[11:2];
      if (a == 4'd14) begin
         m_sleep = 1;
      end else begin
         m_sleep = 0;
         if (a >= 4'd1 && a <= 4'd4) m_code[a-1] = d;
         else if (a == 4'd15) for (int i = 0; i < 4; i++) m_code[i] = d;
      end
   endfunction

   task automatic check_state(input string tag);
      for (int i = 0; i < 4; i++)
         chk(tag, 32'(dac_codes[i*10 +: 10]), 32'(m_code[i]));
      chk(tag, 32'(sleep_flag), 32'(m_sleep));
   endtask

   task automatic clock_bit(input logic b, output logic seen);
      din = b;
      #2 sck = 1'b1;
      #5 sck = 1'b0;
      #3 seen = dout;
   endtask

   task automatic send_word(input logic [15:0] w, input string tag);
      logic s;
      cs_ld = 1'b0;
      #5;
      for (int i = 15; i >= 0; i--) clock_bit(w[i], s);
      #2 cs_ld = 1'b1;
      #5;
      model_load(w);
      check_state(tag);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic        s;
      logic [15:0] w;
      logic [31:0] stream;
      logic        d_before;
      void'($urandom(32'hC0DE_5EED));
      for (int i = 0; i < 4; i++) m_code[i] = '0;
      m_sleep = 0;

      #20;
      // R9 reset state
      check_state("R9 reset");
      chk("R9 reset dout", 32'(dout), 0);
      rst_n = 1'b1;
      #10;

      // R2 single channels
      send_word({4'd1, 10'h101, 2'b00}, "R2 write ch0");
      send_word({4'd2, 10'h202, 2'b00}, "R2 write ch1");
      send_word({4'd3, 10'h303, 2'b00}, "R2 write ch2");
      send_word({4'd4, 10'h0A4, 2'b00}, "R2 write ch3");
      // R1 ignored trailing bits
      send_word({4'd4, 10'h0F0, 2'b11}, "R1 trailing bits ignored");
      // R3 broadcast
      send_word({4'd15, 10'h3C5, 2'b01}, "R3 broadcast");
      send_word({4'd2, 10'h011, 2'b10}, "R2 after broadcast");
      // R4 no-op addresses
      send_word({4'd0, 10'h3FF, 2'b11}, "R4 addr 0");
      for (int a = 5; a <= 13; a++)
         send_word({4'(a), 10'h3FF, 2'b11}, "R4 reserved addr");
      // R5 sleep, R6 wake by write
      send_word({4'd14, 10'h3FF, 2'b11}, "R5 sleep");
      send_word({4'd3, 10'h055, 2'b00}, "R6 wake by write");
      // R6 wake by no-op
      send_word({4'd14, 10'h000, 2'b00}, "R5 sleep again");
      send_word({4'd0, 10'h2AA, 2'b00}, "R6 wake by no-op");

      // R7 clocks ignored while strobe high
      send_word({4'd1, 10'h155, 2'b00}, "R7 setup");
      d_before = dout;
      for (int i = 0; i < 16; i++) begin
         din = (i < 14);
         #2 sck = 1'b1;
         #5 sck = 1'b0;
         #3;
      end
      chk("R7 dout held", 32'(dout), 32'(d_before));
      cs_ld = 1'b0;
      #10 cs_ld = 1'b1;
      #5;
      model_load({4'd1, 10'h155, 2'b00});
      check_state("R7 reload without clocks");

      // R1/R2/R3/R4/R5/R6 random traffic
      for (int n = 0; n < 300; n++) begin
         w = 16'($urandom);
         send_word(w, "R1 random word");
      end

      // R8 chain of two
      stream = {4'd2, 10'h19C, 2'b10, 4'd3, 10'h2A5, 2'b01};
      cs_ld = 1'b0;
      cs_tail = 1'b0;
      #5;
      for (int k = 1; k <= 32; k++) begin
         clock_bit(stream[32-k], s);
         if (k >= 16)
            chk("R8 dout delay", 32'(s), 32'(stream[31-(k-16)]));
      end
      #2;
      cs_ld = 1'b1;
      cs_tail = 1'b1;
      #5;
      model_load(stream[15:0]);
      check_state("R8 head word");
      chk("R8 tail ch0", 32'(codes_tail[9:0]), 0);
      chk("R8 tail ch1", 32'(codes_tail[19:10]), 32'h19C);
      chk("R8 tail ch2", 32'(codes_tail[29:20]), 0);
      chk("R8 tail ch3", 32'(codes_tail[39:30]), 0);
      chk("R8 tail sleep", 32'(sleep_tail), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule